// File: doc/BRIEF.md
# Hint-Based Unit Clock Gating

This block decides, for each of five transactional units, whether that unit's clock runs. Software writes a per-unit hint into a small register. A cleared hint asks for that unit's clock to stop. The request takes effect only when the unit reports that it is idle, so a unit that is busy keeps its clock until it finishes.

The hint register sits in the bus clock domain. Its value passes through a chain of synchronizer flops before it reaches the gating decision. A domain-wide enable from the power manager can switch every unit clock off. A 4-bit multi-bit scan-mode input forces every unit clock on, and it acts combinationally with no clock edge involved. The outputs are per-unit enables meant for a clock-gating cell. A read-only status register reports which clocks are actually running.

Top module: `hint_clk_gate`

## Requirements
- R1: When reset is released, the hint register holds all ones. With the domain enable high and scan inactive, every unit enable is then high.
- R2: A hint write changes the unit enables exactly SYNC_STAGES (default 2) clock edges after the edge that accepts the write. The enables keep their old value up to that edge.
- R3: While a unit's idle bit is low and the domain enable is high, that unit's enable stays high whatever its hint holds.
- R4: If a unit's synchronized hint is clear, its enable falls in the same cycle that its idle bit rises, with no extra register delay.
- R5: When the domain enable is low and scan is inactive, every unit enable is low. Busy units are included.
- R6: Scan mode is active only when scan_mode_i equals 4'b0110. While it is active, every unit enable is high at once, without a clock edge. Any other code has no effect.
- R7: Each unit's enable depends only on its own hint bit and idle bit. Changing one unit's hint leaves the other enables unchanged.
- R8: Register address 0 is the hint register: it can be written and read back. Address 1 is the status register: it reads the current unit enables, and writes to it are ignored.
- R9: Bit positions are the same in the hint, status, idle and enable vectors: bit 0 AES, bit 1 HMAC, bit 2 KMAC, bit 3 OTBN io-side, bit 4 OTBN main-side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 hint, 1 status |
| reg_wdata_i | input | 5 | Write data |
| reg_rdata_o | output | 5 | Read data for the selected register (combinational) |
| unit_idle_i | input | 5 | Per-unit idle, high when the unit is idle |
| dom_en_i | input | 1 | Power-manager enable for the clock domain |
| scan_mode_i | input | 4 | Multi-bit scan mode, active at 4'b0110 |
| unit_en_o | output | 5 | Per-unit clock enable |

## Verification
A hint write is due on unit_en_o at the third falling edge after the write is presented. The second falling edge must still show the old value, which confirms the two-stage latency. Idle, domain-enable and read-address changes are combinational, so the enable or read data must show them by the next falling edge. Scan mode is also sampled a nanosecond after it changes, before any clock edge, to show that it acts asynchronously. Every expected item carries the cycle in which it is due, and the monitor compares it only at that cycle.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
  localparam logic [3:0] SCAN_TRUE = 4'b0110;

  typedef enum logic {
    REG_HINT   = 1'b0,
    REG_STATUS = 1'b1
  } reg_sel_e;

  // bit positions shared by hint, status, idle and enable vectors
  typedef enum int {
    UNIT_AES       = 0,
    UNIT_HMAC      = 1,
    UNIT_KMAC      = 2,
    UNIT_OTBN_IO   = 3,
    UNIT_OTBN_MAIN = 4
  } unit_e;
endpackage

// File: rtl/hcg_sync.sv
module hcg_sync #(
  parameter int          W         = 5,
  parameter int          STAGES    = 2,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= RESET_VAL;
    else         stg[0] <= d_i;
  end

  AST_SYNC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 stg[0] == $past(d_i)); // R2

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= RESET_VAL;
      else         stg[i] <= stg[i-1];
    end

    AST_SYNC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ##1 stg[i] == $past(stg[i-1])); // R2
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hcg_hint_reg.sv
module hcg_hint_reg
  import hcg_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         addr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] status_i,
  output logic [N-1:0] rdata_o,
  output logic [N-1:0] hint_o
);
  logic [N-1:0] hint_q;
  logic         hint_wr;

  assign hint_wr = we_i && (addr_i == REG_HINT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hint_q <= '1;
    else if (hint_wr) hint_q <= wdata_i;
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_HINT:   rdata_o = hint_q;
      REG_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end

  assign hint_o = hint_q;

  AST_HINT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_HINT) |=> hint_q == $past(wdata_i)); // R8
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STATUS) |=> $stable(hint_q)); // R8
  AST_HINT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(hint_q)); // R2
endmodule

// File: rtl/hcg_unit_gate.sv
module hcg_unit_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hint_sync_i,
  input  logic idle_i,
  input  logic dom_en_i,
  input  logic scan_on_i,
  output logic en_o
);
  logic want_run;

  // a busy unit overrides a stop request
  assign want_run = hint_sync_i | ~idle_i;
  assign en_o     = scan_on_i | (dom_en_i & want_run);

  AST_BUSY_KEEPS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dom_en_i && !idle_i) |-> en_o); // R3
  AST_DOM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dom_en_i && !scan_on_i) |-> !en_o); // R5
  AST_IDLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(idle_i) && !hint_sync_i && !scan_on_i) |-> !en_o); // R4
endmodule

// File: rtl/hint_clk_gate.sv
module hint_clk_gate
  import hcg_pkg::*;
#(
  parameter int NUM_UNITS   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic                 reg_addr_i,
  input  logic [NUM_UNITS-1:0] reg_wdata_i,
  output logic [NUM_UNITS-1:0] reg_rdata_o,
  input  logic [NUM_UNITS-1:0] unit_idle_i,
  input  logic                 dom_en_i,
  input  logic [3:0]           scan_mode_i,
  output logic [NUM_UNITS-1:0] unit_en_o
);
  localparam logic [NUM_UNITS-1:0] HINT_RST = '1;

  logic [NUM_UNITS-1:0] hint_q;
  logic [NUM_UNITS-1:0] hint_sync;
  logic                 scan_on;

  // scan decode stays off the synchronizers: asynchronous force
  assign scan_on = (scan_mode_i == SCAN_TRUE);

  hcg_hint_reg #(.N(NUM_UNITS)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (unit_en_o),
    .rdata_o  (reg_rdata_o),
    .hint_o   (hint_q)
  );

  hcg_sync #(.W(NUM_UNITS), .STAGES(SYNC_STAGES), .RESET_VAL(HINT_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hint_q),
    .q_o    (hint_sync)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    hcg_unit_gate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hint_sync_i (hint_sync[u]),
      .idle_i      (unit_idle_i[u]),
      .dom_en_i    (dom_en_i),
      .scan_on_i   (scan_on),
      .en_o        (unit_en_o[u])
    );
  end

  AST_SCAN_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_mode_i == 4'b0110) |-> (&unit_en_o)); // R6
  AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 1'b1) |-> (reg_rdata_o == unit_en_o)); // R8
  AST_RESET_ALL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_ni) && dom_en_i) |-> (&unit_en_o)); // R1
endmodule

// File: tb/hint_clk_gate_tb_top.sv
`timescale 1ns/1ps
module hint_clk_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [4:0] wdata = '0;
  logic [4:0] rdata;
  logic [4:0] idle = 5'h1F;
  logic       dom = 1'b1;
  logic [3:0] scan = 4'h0;
  logic [4:0] en;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int       due;
    logic [4:0] val;
    bit       is_rd;
    string    rq;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hint_clk_gate dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .unit_idle_i (idle),
    .dom_en_i    (dom),
    .scan_mode_i (scan),
    .unit_en_o   (en)
  );

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string rq);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  task automatic push(input int due, input logic [4:0] v, input bit is_rd, input string rq);
    item_t it;
    it.due = due; it.val = v; it.is_rd = is_rd; it.rq = rq;
    q.push_back(it);
  endtask

  // monitor: compare each item at the cycle it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.is_rd ? rdata : en, it.val, it.rq);
    end
  end

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // write: accept edge is next posedge; new enable visible after 2 more edges
  task automatic wr(input logic a, input logic [4:0] d,
                    input logic [4:0] old_en, input logic [4:0] new_en, input string rq);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    push(cyc + 2, old_en, 1'b0, rq);
    push(cyc + 3, new_en, 1'b0, rq);
    @(negedge clk);
    we = 1'b0;
    drain();
  endtask

  task automatic rd(input logic a, input logic [4:0] exp, input string rq);
    @(negedge clk);
    addr = a;
    push(cyc + 1, exp, 1'b1, rq);
    drain();
  endtask

  task automatic expect_en(input logic [4:0] v, input string rq);
    push(cyc + 1, v, 1'b0, rq);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(en, 5'h1F, "R1 in reset");
    rst_n = 1'b1;
    rd(1'b0, 5'h1F, "R1 hint reset value");
    expect_en(5'h1F, "R1 all running");

    // AES stop request, bit 0
    wr(1'b0, 5'h1E, 5'h1F, 5'h1E, "R2 R9 AES stop latency");

    // HMAC busy holds its clock
    @(negedge clk); idle[1] = 1'b0;
    wr(1'b0, 5'h1C, 5'h1E, 5'h1E, "R3 HMAC busy hint cleared");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); expect_en(5'h1E, "R3 HMAC held while busy");
    end
    @(negedge clk); idle[1] = 1'b1;
    expect_en(5'h1C, "R4 HMAC stops on idle");

    // domain enable
    @(negedge clk); dom = 1'b0;
    expect_en(5'h00, "R5 domain off");
    @(negedge clk); idle[3] = 1'b0;
    expect_en(5'h00, "R5 domain off busy unit");

    // scan overrides, asynchronously
    @(negedge clk); scan = 4'b0110;
    #1 chk(en, 5'h1F, "R6 scan async force");
    expect_en(5'h1F, "R6 scan force");
    @(negedge clk); scan = 4'b1110;
    expect_en(5'h00, "R6 non-true scan code ignored");
    @(negedge clk); scan = 4'b0000; dom = 1'b1;
    expect_en(5'h1C, "R5 domain back on");
    @(negedge clk); idle = 5'h1F;
    expect_en(5'h1C, "R7 idle restore");

    // independence: only OTBN main-side changes
    wr(1'b0, 5'h0C, 5'h1C, 5'h0C, "R7 R9 single unit change");

    // register map
    rd(1'b1, 5'h0C, "R8 status read");
    wr(1'b1, 5'h1F, 5'h0C, 5'h0C, "R8 status write ignored");
    rd(1'b0, 5'h0C, "R8 hint unchanged after status write");

    // KMAC busy then idle with all hints cleared
    @(negedge clk); idle[2] = 1'b0;
    wr(1'b0, 5'h00, 5'h0C, 5'h04, "R3 KMAC busy all hints clear");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); expect_en(5'h04, "R3 KMAC held while busy");
    end
    @(negedge clk); idle[2] = 1'b1;
    expect_en(5'h00, "R4 KMAC stops on idle");
    rd(1'b1, 5'h00, "R8 status all stopped");

    @(negedge clk); scan = 4'b0110;
    #1 chk(en, 5'h1F, "R6 scan with hints clear");
    @(negedge clk); scan = 4'b0000;
    expect_en(5'h00, "R6 scan release");

    wr(1'b0, 5'h1F, 5'h00, 5'h1F, "R2 all restart");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule